// File: doc/BRIEF.md
# Four-Pin General-Purpose I/O Port with Standby Control

This block is a small memory-mapped I/O port that serves four pads. A CPU reaches it over a simple register bus with a chip select, one address bit, separate write and read strobes, and 8-bit write and read data. Two 8-bit registers sit behind the bus. The direction register sets each pin as an output or an input. The data register holds the values to drive. Only the low four bits of each register hold state. The upper nibble is locked at 1.

The port drives a per-pin output enable and output value to the pads. It samples the pad input levels through a synchronizer. A data-register read merges the stored data for output pins with the synchronized pad level for input pins. The direction register can be written but never read back.

Two standby inputs and a mode input change how the port behaves:
- Hardware standby returns both registers to their reset state.
- Software standby leaves the registers and the pin drive as they are.
- The expanded operating modes force every pin to be an output.

Top module: `gpio4_port`

## Requirements
- R1: Bits 7..4 of both registers hold no state. Writes to them have no effect, and a data-register read (addr_i=1) always returns 1 in rdata_o[7:4].
- R2: The direction register (addr_i=0) is write-only. A read at that address returns 0xFF whatever was written.
- R3: An active-low rst_ni, and any rising clock edge with hw_stby_i high, put both registers at 0xF0, so every stored direction and data bit is 0. In that same edge hardware standby wins over a bus write.
- R4: While sw_stby_i is high, both registers keep their contents. pad_oe_o and pad_out_o keep driving the same values. A bus write made during software standby is still accepted.
- R5: On a data-register read, bit i of rdata_o equals stored data bit i when the effective direction bit i is 1. It equals the synchronized pad level of pin i when that bit is 0.
- R6: pad_oe_o equals the effective direction bits (1 = output), and pad_out_o equals the stored data bits.
- R7: When mode_i is 1 or 3, all effective direction bits are 1 and writes to the direction register are ignored. In any other mode the stored direction bits are used and are writable.
- R8: A change on pad_in_i reaches the data-register read value after two rising clock edges, and not after fewer.
- R9: rdata_o is 0x00 when no read is in progress (cs_i and rd_i not both high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hw_stby_i | input | 1 | Hardware standby: clears the registers to their reset state |
| sw_stby_i | input | 1 | Software standby: state is retained |
| mode_i | input | 3 | Operating mode; 1 and 3 force all pins to outputs |
| cs_i | input | 1 | Bus chip select |
| addr_i | input | 1 | Register select: 0 = direction, 1 = data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| pad_in_i | input | 4 | Pad input levels, asynchronous |
| pad_oe_o | output | 4 | Per-pin output enable |
| pad_out_o | output | 4 | Per-pin output value |

## Verification
The assertions check three things on every cycle:
- the locked upper read nibble and the constant 0xFF direction readback;
- the clear on hardware standby;
- register retention during software standby when no write is made, and the blocking of direction writes in the forced modes.

Other behaviours can only be shown by the bench's scenarios. These are the per-bit merge of stored data and pad level, the two-edge synchronizer latency, hardware standby winning over a same-cycle write, and acceptance of writes during software standby. The bench checks them against a model of the requirements under random bus traffic, pad changes and mode changes.

// File: rtl/gpio4_pkg.sv
package gpio4_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned PIN_W = 4;

  typedef enum logic {
    SEL_DIR = 1'b0,
    SEL_DAT = 1'b1
  } reg_sel_e;

  function automatic logic mode_forces_out(input logic [2:0] mode);
    return (mode == 3'd1) || (mode == 3'd3);
  endfunction
endpackage

// File: rtl/gpio4_sync.sv
module gpio4_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          stage_q[s] <= '0;
        end else begin
          if (s == 0) stage_q[s] <= d_i;
          else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio4_regs.sv
module gpio4_regs #(
  parameter int unsigned PIN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hw_stby_i,
  input  logic             sw_stby_i,
  input  logic             forced_i,
  input  logic             wr_dir_i,
  input  logic             wr_dat_i,
  input  logic [PIN_W-1:0] wdata_i,
  output logic [PIN_W-1:0] dir_q_o,
  output logic [PIN_W-1:0] dat_q_o
);
  logic [PIN_W-1:0] dir_q, dat_q;

  // hardware standby takes priority over any write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      dat_q <= '0;
    end else if (hw_stby_i) begin
      dir_q <= '0;
      dat_q <= '0;
    end else begin
      if (wr_dir_i && !forced_i) dir_q <= wdata_i;
      if (wr_dat_i)              dat_q <= wdata_i;
    end
  end

  assign dir_q_o = dir_q;
  assign dat_q_o = dat_q;

  p_hwstby_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_stby_i |=> (dir_q == '0) && (dat_q == '0));

  p_swstby_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_stby_i && !hw_stby_i && !wr_dir_i && !wr_dat_i) |=> $stable(dir_q) && $stable(dat_q));

  p_forced_dir_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (forced_i && !hw_stby_i) |=> $stable(dir_q));
endmodule

// File: rtl/gpio4_rdmux.sv
module gpio4_rdmux
  import gpio4_pkg::*;
#(
  parameter int unsigned PIN_W = 4,
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  reg_sel_e         sel_i,
  input  logic [PIN_W-1:0] dir_eff_i,
  input  logic [PIN_W-1:0] dat_q_i,
  input  logic [PIN_W-1:0] pin_s_i,
  output logic [REG_W-1:0] rdata_o
);
  localparam int unsigned RSV_W = REG_W - PIN_W;

  logic [PIN_W-1:0] merged;

  always_comb begin
    for (int i = 0; i < PIN_W; i++) begin
      merged[i] = dir_eff_i[i] ? dat_q_i[i] : pin_s_i[i];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (sel_i == SEL_DIR) rdata_o = '1;
      else                  rdata_o = {{RSV_W{1'b1}}, merged};
    end
  end

  p_rsv_ones_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sel_i == SEL_DAT) |-> (rdata_o[REG_W-1:PIN_W] == {RSV_W{1'b1}}));

  p_dir_unreadable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sel_i == SEL_DIR) |-> (rdata_o == {REG_W{1'b1}}));

  p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (rdata_o == '0));
endmodule

// File: rtl/gpio4_port.sv
module gpio4_port
  import gpio4_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hw_stby_i,
  input  logic             sw_stby_i,
  input  logic [2:0]       mode_i,
  input  logic             cs_i,
  input  logic             addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic [PIN_W-1:0] pad_in_i,
  output logic [PIN_W-1:0] pad_oe_o,
  output logic [PIN_W-1:0] pad_out_o
);
  logic             forced;
  logic             wr_dir, wr_dat, rd_en;
  logic [PIN_W-1:0] dir_q, dat_q, dir_eff, pin_s;
  reg_sel_e         sel;
  logic             unused_rsv;

  assign forced  = mode_forces_out(mode_i);
  assign sel     = reg_sel_e'(addr_i);
  assign wr_dir  = cs_i && wr_i && (sel == SEL_DIR);
  assign wr_dat  = cs_i && wr_i && (sel == SEL_DAT);
  assign rd_en   = cs_i && rd_i;
  assign dir_eff = forced ? {PIN_W{1'b1}} : dir_q;
  // reserved write bits carry no state
  assign unused_rsv = ^wdata_i[REG_W-1:PIN_W];

  gpio4_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pin_s)
  );

  gpio4_regs #(.PIN_W(PIN_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_stby_i (hw_stby_i),
    .sw_stby_i (sw_stby_i),
    .forced_i  (forced),
    .wr_dir_i  (wr_dir),
    .wr_dat_i  (wr_dat),
    .wdata_i   (wdata_i[PIN_W-1:0]),
    .dir_q_o   (dir_q),
    .dat_q_o   (dat_q)
  );

  gpio4_rdmux #(.PIN_W(PIN_W), .REG_W(REG_W)) u_rdmux (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en),
    .sel_i     (sel),
    .dir_eff_i (dir_eff),
    .dat_q_i   (dat_q),
    .pin_s_i   (pin_s),
    .rdata_o   (rdata_o)
  );

  assign pad_oe_o  = dir_eff;
  assign pad_out_o = dat_q;

  p_oe_forced_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == 3'd1) || (mode_i == 3'd3)) |-> (pad_oe_o == {PIN_W{1'b1}}));

  p_out_hold_swstby_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_stby_i && !hw_stby_i && !(cs_i && wr_i) && $stable(mode_i)) |=> $stable(pad_out_o));
endmodule

// File: tb/tb_gpio4_port.sv
`timescale 1ns/1ps
module tb_gpio4_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hw_stby_i = 1'b0, sw_stby_i = 1'b0;
  logic [2:0] mode_i = 3'd5;
  logic       cs_i = 1'b0, addr_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [3:0] pad_in_i = '0;
  logic [3:0] pad_oe_o, pad_out_o;

  int checks = 0, fails = 0, cycles = 0;
  logic [3:0] m_dir = '0, m_dat = '0, m_pad = '0;
  logic [7:0] r;

  always #2.5 clk_i = ~clk_i;

  gpio4_port dut (.*);

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic forced_m();
    return (mode_i == 3'd1) || (mode_i == 3'd3);
  endfunction

  function automatic logic [3:0] eff_dir();
    return forced_m() ? 4'hF : m_dir;
  endfunction

  function automatic logic [7:0] exp_rd(input logic a);
    if (!a) return 8'hFF;
    return {4'hF, (eff_dir() & m_dat) | (~eff_dir() & m_pad)};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk_i);
    cs_i = 1; wr_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    cs_i = 0; wr_i = 0;
    if (a) m_dat = d[3:0];
    else if (!forced_m()) m_dir = d[3:0];
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] d);
    @(negedge clk_i);
    cs_i = 1; rd_i = 1; addr_i = a;
    #1 d = rdata_o;
    cs_i = 0; rd_i = 0;
  endtask

  task automatic set_pad(input logic [3:0] p);
    @(negedge clk_i);
    pad_in_i = p;
    repeat (3) @(negedge clk_i);
    m_pad = p;
  endtask

  task automatic hw_pulse();
    @(negedge clk_i);
    hw_stby_i = 1;
    @(negedge clk_i);
    hw_stby_i = 0;
    m_dir = '0; m_dat = '0;
  endtask

  task automatic chk_pads(input string req);
    #1;
    chk({req, " oe"},  {4'h0, pad_oe_o},  {4'h0, eff_dir()});
    chk({req, " out"}, {4'h0, pad_out_o}, {4'h0, m_dat});
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R3 reset state, R9 idle bus
    bus_rd(1'b1, r); chk("R3 reset data read", r, 8'hF0);
    bus_rd(1'b0, r); chk("R2 dir read after reset", r, 8'hFF);
    chk_pads("R3 reset pads");
    #1 chk("R9 idle rdata", rdata_o, 8'h00);

    // R1 reserved bits ignore writes
    bus_wr(1'b1, 8'h05);
    bus_wr(1'b0, 8'h0F);
    bus_rd(1'b1, r); chk("R1 reserved read ones", r, 8'hF5);
    bus_rd(1'b0, r); chk("R2 dir write-only", r, 8'hFF);
    chk_pads("R6 all outputs");

    // R5 per-bit merge
    set_pad(4'b1010);
    bus_wr(1'b0, 8'hF3);
    bus_wr(1'b1, 8'h0C);
    bus_rd(1'b1, r); chk("R5 mixed merge", r, 8'hF8);

    // R8 synchronizer latency
    bus_wr(1'b0, 8'h00);
    set_pad(4'h0);
    @(negedge clk_i); pad_in_i = 4'hF;
    #1 cs_i = 1; rd_i = 1; addr_i = 1;
    #1 chk("R8 no edge yet", rdata_o, 8'hF0);
    cs_i = 0; rd_i = 0;
    @(negedge clk_i); cs_i = 1; rd_i = 1;
    #1 chk("R8 one edge", rdata_o, 8'hF0);
    cs_i = 0; rd_i = 0;
    @(negedge clk_i); cs_i = 1; rd_i = 1;
    #1 chk("R8 two edges", rdata_o, 8'hFF);
    cs_i = 0; rd_i = 0;
    m_pad = 4'hF;

    // R3 hardware standby wins over same-cycle write
    bus_wr(1'b0, 8'h0F);
    bus_wr(1'b1, 8'h09);
    @(negedge clk_i);
    hw_stby_i = 1; cs_i = 1; wr_i = 1; addr_i = 1; wdata_i = 8'h06;
    @(negedge clk_i);
    hw_stby_i = 0; cs_i = 0; wr_i = 0;
    m_dir = '0; m_dat = '0;
    chk_pads("R3 hw standby over write");
    bus_rd(1'b1, r); chk("R3 hw standby read", r, exp_rd(1'b1));

    // R4 software standby retention and write acceptance
    bus_wr(1'b0, 8'h0A); bus_wr(1'b1, 8'h0E);
    @(negedge clk_i); sw_stby_i = 1;
    repeat (5) @(negedge clk_i);
    chk_pads("R4 hold in sw standby");
    bus_wr(1'b1, 8'h03);
    chk_pads("R4 write during sw standby");
    @(negedge clk_i); sw_stby_i = 0;

    // R7 forced modes
    mode_i = 3'd1;
    bus_wr(1'b0, 8'h00);
    chk_pads("R7 mode1 forced");
    bus_rd(1'b1, r); chk("R7 mode1 read data", r, exp_rd(1'b1));
    mode_i = 3'd6;
    chk_pads("R7 mode6 stored dir kept");
    bus_wr(1'b0, 8'h05);
    chk_pads("R7 mode6 writable");

    // random traffic
    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom_range(0, 6);
      case (op)
        0: bus_wr(1'b0, 8'($urandom));
        1: bus_wr(1'b1, 8'($urandom));
        2: begin bus_rd(1'b1, r); chk("R5 random data read", r, exp_rd(1'b1)); end
        3: begin bus_rd(1'b0, r); chk("R2 random dir read", r, 8'hFF); end
        4: set_pad(4'($urandom));
        5: begin @(negedge clk_i); mode_i = 3'($urandom); sw_stby_i = 1'($urandom); end
        default: if ($urandom_range(0, 3) == 0) hw_pulse();
      endcase
      chk_pads("R6 random pads");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule